// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Matcher

This block decides, once per second, whether the running calendar time has reached a programmed alarm. The running time and date and the alarm time and date all arrive as 32-bit BCD words with one fixed layout. Every field of the alarm (second, minute, hour, day, month, year, weekday) carries its own mask bit. A masked field drops out of the comparison, so a single alarm setting can describe a daily, hourly or weekly event as well as one exact instant.

The comparison runs only in the cycle of a one-second update strobe. A match sets a sticky alarm flag. Software clears the flag by writing 1 to it, and an interrupt line follows the flag whenever the interrupt enable is high. Hours are compared as a time of day rather than as raw bits. In 12-hour mode this accounts for the PM marker, and it treats the "12" of a half-day as hour zero. The counters that advance the time are outside this block and feed it through the `now_*` inputs.

Top module: `bcd_alarm_matcher`

## Requirements
- R1: After reset, alarm_flag_o and alarm_irq_o are 0.
- R2: In the time words, the seconds are bits [6:4] (tens) and [3:0] (units) and the minutes are bits [14:12] and [11:8]. When no field is masked and every field of the running words equals the alarm, a strobe on tick_i sets alarm_flag_o at the next clock edge.
- R3: A time-word mask bit of 1 removes its field from the compare: bit 7 for seconds, bit 15 for minutes, bit 23 for hours. A mask bit of 0 keeps the field in the compare.
- R4: In the date words, the day is [5:4],[3:0] with its mask at bit 7, the month is [12],[11:8] with its mask at bit 15, the year is [23:20],[19:16] with its mask at bit 24, and the weekday is [30:28] (0 = Sunday to 6 = Saturday) with its mask at bit 31. A difference in any unmasked field blocks the match.
- R5: With mode24_i = 0, the hour field [21:16] reads as PM flag [21], tens [20] and units [19:16]. The hour is compared as a time of day: 12 AM, 00 AM and hour zero are the same hour, and 12 PM is noon.
- R6: With mode24_i = 1, the hour field is tens [21:20] (0-2) and units [19:16], and it is compared as a whole hour 0-23.
- R7: A match only counts in a cycle with tick_i = 1. Matching inputs without the strobe leave the flag unchanged.
- R8: Once set, the flag stays 1 through later strobes that do not match.
- R9: A cycle with ack_wr_i = 1 and ack_data_i = 1 clears the flag. A write with ack_data_i = 0 has no effect on it.
- R10: When a matching strobe and a clearing write fall in the same cycle, the flag ends up set.
- R11: alarm_irq_o is 1 exactly when the flag is 1 and irq_en_i is 1.
- R12: With all seven mask bits set, every strobe counts as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second update strobe, one cycle wide |
| mode24_i | input | 1 | 1 = 24-hour scale, 0 = 12-hour scale with PM bit |
| now_time_i | input | 32 | Running time word (mask bits ignored) |
| now_date_i | input | 32 | Running date word including weekday (mask bits ignored) |
| alm_time_i | input | 32 | Alarm time word with mask bits |
| alm_date_i | input | 32 | Alarm date word with mask bits |
| irq_en_i | input | 1 | Alarm interrupt enable |
| ack_wr_i | input | 1 | Write strobe to the flag |
| ack_data_i | input | 1 | Write data; 1 clears the flag |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| alarm_irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with its default 32-bit word width, since the field layout fixes every position and leaves no parameter to shrink. At that size two sweeps fit easily in the run. The first covers all 24 × 24 alarm and running hours in both hour scales, plus the "00 AM" spelling of midnight. The second covers all 128 mask patterns, each crossed with a mismatch in each of the seven fields and with no mismatch at all. The flag timing cases (no strobe, a clear, a set that collides with a clear, and the interrupt gate) are run as directed sequences.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_FIELDS = 6;     // plain fields; hour handled separately

    // Plain field table: sec, min (time word); day, mon, year, wday (date word)
    localparam int FLD_LO   [NUM_FIELDS] = '{0, 8, 0, 8, 16, 28};
    localparam int FLD_W    [NUM_FIELDS] = '{7, 7, 6, 5, 8, 3};
    localparam int FLD_MSK  [NUM_FIELDS] = '{7, 15, 7, 15, 24, 31};
    localparam bit FLD_DATE [NUM_FIELDS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    localparam int HR_LO  = 16;
    localparam int HR_W   = 6;
    localparam int HR_MSK = 23;
    localparam int HOD_W  = 6;         // width of a binary hour of day
    localparam int NUM_HITS = NUM_FIELDS + 1;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    // Turn a BCD hour field into a binary hour of day 0..23
    function automatic logic [HOD_W-1:0] hour_of_day(input logic [HR_W-1:0] f,
                                                     input logic mode24);
        logic [HOD_W-1:0] tens;
        logic [HOD_W-1:0] h;
        if (mode24) tens = {{(HOD_W-2){1'b0}}, f[5:4]};
        else        tens = {{(HOD_W-1){1'b0}}, f[4]};
        h = (tens << 3) + (tens << 1) + {{(HOD_W-4){1'b0}}, f[3:0]};
        if (!mode24) begin
            if (h == HOD_W'(12)) h = '0;
            if (f[5])            h = h + HOD_W'(12);
        end
        return h;
    endfunction

endpackage

// File: rtl/bcd_field_cmp.sv
module bcd_field_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] alarm_i,
    input  logic [W-1:0] now_i,
    input  logic         mask_i,
    output logic         hit_o
);
    always_comb begin
        hit_o = mask_i || (alarm_i == now_i);
    end
endmodule

// File: rtl/bcd_hour_cmp.sv
module bcd_hour_cmp
    import bcd_alarm_pkg::*;
(
    input  logic [HR_W-1:0] alarm_i,
    input  logic [HR_W-1:0] now_i,
    input  logic            mask_i,
    input  logic            mode24_i,
    output logic            hit_o
);
    logic [HOD_W-1:0] alarm_hod;
    logic [HOD_W-1:0] now_hod;

    always_comb begin
        alarm_hod = hour_of_day(alarm_i, mode24_i);
        now_hod   = hour_of_day(now_i, mode24_i);
        hit_o     = mask_i || (alarm_hod == now_hod);
    end
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag
    import bcd_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic match_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)              st_d.flag = 1'b0;
        if (tick_i && match_i)  st_d.flag = 1'b1;   // a new event wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flag_o = st_q.flag;
        irq_o  = st_q.flag && irq_en_i;
    end
endmodule

// File: rtl/bcd_alarm_matcher.sv
module bcd_alarm_matcher
    import bcd_alarm_pkg::*;
#(
    parameter int WORD_W_P = WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                mode24_i,
    input  logic [WORD_W_P-1:0] now_time_i,
    input  logic [WORD_W_P-1:0] now_date_i,
    input  logic [WORD_W_P-1:0] alm_time_i,
    input  logic [WORD_W_P-1:0] alm_date_i,
    input  logic                irq_en_i,
    input  logic                ack_wr_i,
    input  logic                ack_data_i,
    output logic                alarm_flag_o,
    output logic                alarm_irq_o
);
    logic [NUM_HITS-1:0] hits;
    logic                match;
    logic                clr;
    logic                unused_bits;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        logic [FLD_W[g]-1:0] a_f;
        logic [FLD_W[g]-1:0] n_f;
        logic                m_f;
        if (FLD_DATE[g]) begin : g_date
            assign a_f = alm_date_i[FLD_LO[g] +: FLD_W[g]];
            assign n_f = now_date_i[FLD_LO[g] +: FLD_W[g]];
            assign m_f = alm_date_i[FLD_MSK[g]];
        end else begin : g_time
            assign a_f = alm_time_i[FLD_LO[g] +: FLD_W[g]];
            assign n_f = now_time_i[FLD_LO[g] +: FLD_W[g]];
            assign m_f = alm_time_i[FLD_MSK[g]];
        end
        bcd_field_cmp #(.W(FLD_W[g])) u_cmp (
            .alarm_i (a_f),
            .now_i   (n_f),
            .mask_i  (m_f),
            .hit_o   (hits[g])
        );
    end

    bcd_hour_cmp u_hour (
        .alarm_i  (alm_time_i[HR_LO +: HR_W]),
        .now_i    (now_time_i[HR_LO +: HR_W]),
        .mask_i   (alm_time_i[HR_MSK]),
        .mode24_i (mode24_i),
        .hit_o    (hits[NUM_HITS-1])
    );

    always_comb begin
        match       = &hits;
        clr         = ack_wr_i && ack_data_i;
        unused_bits = ^{now_time_i, now_date_i, alm_time_i, alm_date_i};
    end

    bcd_alarm_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .match_i  (match),
        .clr_i    (clr),
        .irq_en_i (irq_en_i),
        .flag_o   (alarm_flag_o),
        .irq_o    (alarm_irq_o)
    );
endmodule

// File: rtl/bcd_alarm_checker.sv
module bcd_alarm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic [31:0] alm_time_i,
    input logic [31:0] alm_date_i,
    input logic        irq_en_i,
    input logic        ack_wr_i,
    input logic        ack_data_i,
    input logic        alarm_flag_o,
    input logic        alarm_irq_o
);
    logic all_masked;
    assign all_masked = alm_time_i[7] && alm_time_i[15] && alm_time_i[23] &&
                        alm_date_i[7] && alm_date_i[15] && alm_date_i[24] && alm_date_i[31];

    assert_set_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag_o) |-> $past(tick_i));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(ack_wr_i && ack_data_i)) |=> $stable(alarm_flag_o));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_i && ack_data_i && !tick_i) |=> !alarm_flag_o);

    assert_set_wins_R10_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && all_masked) |=> alarm_flag_o);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_i || !alarm_flag_o) |-> !alarm_irq_o);
endmodule

bind bcd_alarm_matcher bcd_alarm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .alm_time_i   (alm_time_i),
    .alm_date_i   (alm_date_i),
    .irq_en_i     (irq_en_i),
    .ack_wr_i     (ack_wr_i),
    .ack_data_i   (ack_data_i),
    .alarm_flag_o (alarm_flag_o),
    .alarm_irq_o  (alarm_irq_o)
);

// File: tb/sim_bcd_alarm_matcher.sv
module sim_bcd_alarm_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        mode24_i = 1'b1;
    logic [31:0] now_time_i = '0;
    logic [31:0] now_date_i = '0;
    logic [31:0] alm_time_i = '0;
    logic [31:0] alm_date_i = '0;
    logic        irq_en_i = 1'b0;
    logic        ack_wr_i = 1'b0;
    logic        ack_data_i = 1'b0;
    logic        alarm_flag_o;
    logic        alarm_irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bcd_alarm_matcher u0 (.*);

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Hour field [21:16] for hour of day h in the chosen scale
    function automatic logic [5:0] enc_hour(input int h, input logic m24);
        int h12;
        logic [7:0] b;
        if (m24) begin
            b = bcd(h);
            return {b[5:4], b[3:0]};
        end
        h12 = (h % 12 == 0) ? 12 : h % 12;
        b = bcd(h12);
        return {(h >= 12) ? 1'b1 : 1'b0, b[4], b[3:0]};
    endfunction

    function automatic logic [31:0] mk_time(input int s, input int m, input logic [5:0] hr,
                                            input logic [2:0] msk);
        logic [31:0] w = '0;
        w[6:0]   = bcd(s)[6:0];
        w[14:8]  = bcd(m)[6:0];
        w[21:16] = hr;
        w[7] = msk[0]; w[15] = msk[1]; w[23] = msk[2];
        return w;
    endfunction

    function automatic logic [31:0] mk_date(input int d, input int mo, input int y, input int wd,
                                            input logic [3:0] msk);
        logic [31:0] w = '0;
        w[5:0]   = bcd(d)[5:0];
        w[12:8]  = bcd(mo)[4:0];
        w[23:16] = bcd(y);
        w[30:28] = 3'(wd);
        w[7] = msk[0]; w[15] = msk[1]; w[24] = msk[2]; w[31] = msk[3];
        return w;
    endfunction

    task automatic clear_flag();
        @(negedge clk);
        ack_wr_i = 1'b1; ack_data_i = 1'b1; tick_i = 1'b0;
        @(negedge clk);
        ack_wr_i = 1'b0; ack_data_i = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic run_case(input logic [31:0] at, input logic [31:0] ad,
                            input logic [31:0] nt, input logic [31:0] nd,
                            input logic m24, input logic exp, input string req);
        clear_flag();
        alm_time_i = at; alm_date_i = ad; now_time_i = nt; now_date_i = nd; mode24_i = m24;
        strobe();
        check(alarm_flag_o, exp, req);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] at, ad, nt, nd;
        repeat (3) @(negedge clk);
        check(alarm_flag_o, 1'b0, "R1 flag after reset");
        check(alarm_irq_o, 1'b0, "R1 irq after reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm_flag_o, 1'b0, "R1 flag after release");

        // Hour sweep, both scales, other fields masked (R5, R6)
        for (int md = 0; md < 2; md++) begin
            for (int ha = 0; ha < 24; ha++) begin
                for (int hn = 0; hn < 24; hn++) begin
                    run_case(mk_time(0, 0, enc_hour(ha, md[0]), 3'b011), mk_date(1, 1, 0, 0, 4'hF),
                             mk_time(0, 0, enc_hour(hn, md[0]), 3'b000), mk_date(1, 1, 0, 0, 4'h0),
                             md[0], (ha == hn), md[0] ? "R6 hour 24h" : "R5 hour 12h");
                end
            end
        end
        // 00 AM spelling equals 12 AM (R5)
        for (int hn = 0; hn < 24; hn++)
            run_case(mk_time(0, 0, 6'h00, 3'b011), mk_date(1, 1, 0, 0, 4'hF),
                     mk_time(0, 0, enc_hour(hn, 1'b0), 3'b000), mk_date(1, 1, 0, 0, 4'h0),
                     1'b0, (hn == 0), "R5 00AM");

        // Mask sweep: 128 patterns x (one differing field or none) (R2, R3, R4)
        for (int m = 0; m < 128; m++) begin
            for (int k = 0; k < 8; k++) begin
                at = mk_time(45, 37, enc_hour(23, 1'b1), m[2:0]);
                ad = mk_date(29, 12, 99, 6, m[6:3]);
                nt = mk_time(k == 0 ? 15 : 45, k == 1 ? 7 : 37,
                             enc_hour(k == 2 ? 3 : 23, 1'b1), 3'b000);
                nd = mk_date(k == 3 ? 9 : 29, k == 4 ? 2 : 12, k == 5 ? 19 : 99,
                             k == 6 ? 0 : 6, 4'h0);
                run_case(at, ad, nt, nd, 1'b1, (k == 7) || m[k],
                         (m == 0) ? "R2 full match" : ((k < 3) ? "R3 time mask" : "R4 date mask"));
            end
        end

        // R7: matching inputs without strobe
        clear_flag();
        alm_time_i = mk_time(1, 2, enc_hour(3, 1'b1), 3'b000);
        alm_date_i = mk_date(4, 5, 6, 1, 4'h0);
        now_time_i = alm_time_i; now_date_i = alm_date_i; mode24_i = 1'b1;
        repeat (4) @(negedge clk);
        check(alarm_flag_o, 1'b0, "R7 no strobe");
        strobe();
        check(alarm_flag_o, 1'b1, "R7 strobe sets");

        // R8: sticky through a non-matching strobe
        now_time_i = mk_time(2, 2, enc_hour(3, 1'b1), 3'b000);
        strobe();
        check(alarm_flag_o, 1'b1, "R8 sticky");

        // R11: interrupt gate
        irq_en_i = 1'b0;
        @(negedge clk);
        check(alarm_irq_o, 1'b0, "R11 disabled");
        irq_en_i = 1'b1;
        @(negedge clk);
        check(alarm_irq_o, 1'b1, "R11 enabled");

        // R9: write 0 ignored, write 1 clears
        ack_wr_i = 1'b1; ack_data_i = 1'b0;
        @(negedge clk);
        ack_wr_i = 1'b0;
        check(alarm_flag_o, 1'b1, "R9 write zero ignored");
        clear_flag();
        check(alarm_flag_o, 1'b0, "R9 write one clears");
        check(alarm_irq_o, 1'b0, "R11 flag clear");

        // R10: set wins over simultaneous clear
        now_time_i = alm_time_i;
        @(negedge clk);
        tick_i = 1'b1; ack_wr_i = 1'b1; ack_data_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0; ack_wr_i = 1'b0; ack_data_i = 1'b0;
        check(alarm_flag_o, 1'b1, "R10 set wins");

        // R12: all masked matches on every strobe
        for (int i = 0; i < 4; i++)
            run_case(mk_time(0, 0, 6'h00, 3'b111), mk_date(0, 0, 0, 0, 4'hF),
                     mk_time(10 + i, 20 + i, enc_hour(i * 5, 1'b1), 3'b000),
                     mk_date(i + 1, i + 2, i * 20, i, 4'h0), 1'b1, 1'b1, "R12 all masked");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule